// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Matcher

This block sits beside a processor-style bus and raises a halt request when a programmed bus event occurs. A cycle starts on the clock in which the address strobe goes high. The address side and the cycle qualifiers are judged on that clock. The data side is judged on the clock in which the cycle's ready is sampled high. Each break condition has its own enable bit and its own bit in a sticky status vector. A condition that fires sets its status bit, and the halt output stays high while any status bit is set.

Address and data are compared against programmed values through per-bit ignore masks. Qualifiers narrow an ordinary cycle match by direction, address space, fetch class and access size. The access size is derived from the number of active byte enables. Separate conditions cover interrupt-acknowledge cycles, cache flush and writeback cycles, undefined cycle-type codes, a bus left idle too long, and a strobe held high too long. Two sync inputs let outside units force a break. Two sync outputs pulse when the halt request first rises, so external instruments can be triggered.

Top module: `bkpt_matcher`

## Requirements
- R1: An ordinary cycle (cycle type 0) matches only if its direction is allowed: cfg_dir bit 0 allows reads (bus_wr=0) and bit 1 allows writes (bus_wr=1). An address match sets status bit 0 at the clock edge where ready is sampled, and the sync outputs pulse in the following cycle.
- R2: The address matches when every bit with cfg_addr_ign=0 equals cfg_addr. When cfg_data_on=1, the data valid at ready must also match cfg_data in every bit with cfg_data_ign=0. The data present at the strobe is not used.
- R3: cfg_fetch selects the fetch class: 0 or 3 means any cycle, 1 means data accesses only (bus_code=0), and 2 means code fetches only (bus_code=1).
- R4: cfg_space bit 0 allows I/O cycles (bus_mio=0) and bit 1 allows memory cycles (bus_mio=1).
- R5: cfg_size selects the access size from the count of active byte enables: 0 means any, 1 means byte (one lane), 2 means word (two lanes) and 3 means double word (four lanes).
- R6: A cycle of type 1 (interrupt acknowledge) sets status bit 2 at its ready edge. The vector in data bits 7:0 must equal cfg_vector unless cfg_vec_any=1.
- R7: A cycle of type 2 (flush) with cfg_spec_sel bit 0 set, or of type 3 (writeback) with cfg_spec_sel bit 1 set, sets status bit 1 on its strobe clock.
- R8: After cfg_idle_limit consecutive clocks sampled with the strobe low, status bit 3 is set at the edge that ends the last of those clocks. This happens once per idle stretch, and a limit of 0 never fires.
- R9: When the strobe is sampled high for more than cfg_hold_limit consecutive clocks, status bit 4 is set on the first clock past the limit. A limit of 0 never fires.
- R10: A cycle whose type code is 4 to 7 sets status bit 5 on its strobe clock.
- R11: sync_in[k] sampled high sets status bit 6+k. When the halt request rises, sync_out[0] pulses for one clock. sync_out[1] pulses with it only when a condition on status bits 0 to 5 caused the rise.
- R12: A condition sets its status bit only while its cfg_en bit is set. With cfg_en all zero, halt never rises.
- R13: halt is the OR of the status bits, and each status bit holds until a one is written to the same bit of stat_clr. A set on the same edge wins over the clear, and bits not named in stat_clr are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_strobe | input | 1 | Address strobe; a rising level starts a cycle |
| bus_rdy | input | 1 | Cycle completion; data is valid with it |
| bus_addr | input | ADDR_W | Cycle address |
| bus_data | input | DATA_W | Cycle data |
| bus_mio | input | 1 | 1 for memory, 0 for I/O |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_code | input | 1 | 1 for a code fetch |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_ctype | input | 3 | Cycle type: 0 ordinary, 1 interrupt acknowledge, 2 flush, 3 writeback, 4-7 undefined |
| cfg_en | input | 8 | Per-condition enables, same order as status |
| cfg_addr | input | ADDR_W | Address compare value |
| cfg_addr_ign | input | ADDR_W | Address bits to ignore |
| cfg_data | input | DATA_W | Data compare value |
| cfg_data_ign | input | DATA_W | Data bits to ignore |
| cfg_data_on | input | 1 | Include data in the ordinary-cycle match |
| cfg_dir | input | 2 | Allowed directions |
| cfg_space | input | 2 | Allowed address spaces |
| cfg_fetch | input | 2 | Fetch class select |
| cfg_size | input | 2 | Access size select |
| cfg_vector | input | 8 | Interrupt vector to match |
| cfg_vec_any | input | 1 | Match any interrupt vector |
| cfg_spec_sel | input | 2 | Bit 0 flush, bit 1 writeback |
| cfg_idle_limit | input | IDLE_W | Idle clocks before a break, 0 off |
| cfg_hold_limit | input | HOLD_W | Longest allowed strobe, 0 off |
| sync_in | input | 2 | External break requests |
| stat_clr | input | 8 | Write-one-to-clear for status bits |
| halt | output | 1 | Sticky halt request |
| status | output | 8 | Fired conditions |
| sync_out | output | 2 | Break pulses for external units |

## Verification
The bench builds the block with a 16-bit address, a 32-bit data bus, a 6-bit idle counter and a 3-bit hold counter. The narrow idle counter lets a long idle stretch run the counter into saturation within a short run, which shows that the idle break fires only once per stretch. The small hold limit lets the over-long strobe break fire after only a few clocks. The 32-bit data bus gives four byte lanes, so byte, word and double-word sizes can each be matched, and the outer-byte data mask can be exercised.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NCOND   = 8;
  localparam int C_ADDR  = 0;
  localparam int C_SPEC  = 1;
  localparam int C_INTA  = 2;
  localparam int C_IDLE  = 3;
  localparam int C_HOLD  = 4;
  localparam int C_ILL   = 5;
  localparam int C_SYNC0 = 6;
  localparam int C_SYNC1 = 7;
  localparam int NLOCAL  = 6;

  localparam logic [2:0] CT_NORMAL = 3'd0;
  localparam logic [2:0] CT_INTA   = 3'd1;
  localparam logic [2:0] CT_FLUSH  = 3'd2;
  localparam logic [2:0] CT_WBACK  = 3'd3;

  typedef enum logic [1:0] {SZ_ANY = 2'd0, SZ_BYTE = 2'd1, SZ_WORD = 2'd2, SZ_DWORD = 2'd3} size_e;
  typedef enum logic [1:0] {FC_ANY = 2'd0, FC_DATA = 2'd1, FC_CODE = 2'd2, FC_ANY2 = 2'd3} fetch_e;

  function automatic logic masked_eq(logic [63:0] a, logic [63:0] b, logic [63:0] ign);
    return ((a ^ b) & ~ign) == 64'd0;
  endfunction

  function automatic logic size_ok(logic [1:0] sel, logic [7:0] be);
    int n;
    n = $countones(be);
    case (sel)
      SZ_ANY:  return 1'b1;
      SZ_BYTE: return n == 1;
      SZ_WORD: return n == 2;
      default: return n == 4;
    endcase
  endfunction

  function automatic logic fetch_ok(logic [1:0] sel, logic code);
    case (sel)
      FC_DATA: return !code;
      FC_CODE: return code;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic dir_ok(logic [1:0] allow, logic wr);
    return wr ? allow[1] : allow[0];
  endfunction

  function automatic logic space_ok(logic [1:0] allow, logic mio);
    return mio ? allow[1] : allow[0];
  endfunction
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              bus_rdy,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_mio,
  input  logic              bus_wr,
  input  logic              bus_code,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [2:0]        bus_ctype,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_addr_ign,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [DATA_W-1:0] cfg_data_ign,
  input  logic              cfg_data_on,
  input  logic [1:0]        cfg_dir,
  input  logic [1:0]        cfg_space,
  input  logic [1:0]        cfg_fetch,
  input  logic [1:0]        cfg_size,
  input  logic [7:0]        cfg_vector,
  input  logic              cfg_vec_any,
  input  logic [1:0]        cfg_spec_sel,
  output logic              ev_addr,
  output logic              ev_spec,
  output logic              ev_inta,
  output logic              ev_ill
);
  logic addr_side_ok;
  logic data_side_ok;
  logic vec_ok;
  logic pend_addr;
  logic pend_inta;

  assign addr_side_ok = (bus_ctype == CT_NORMAL)
                      && dir_ok(cfg_dir, bus_wr)
                      && space_ok(cfg_space, bus_mio)
                      && fetch_ok(cfg_fetch, bus_code)
                      && size_ok(cfg_size, 8'(bus_be))
                      && masked_eq(64'(bus_addr), 64'(cfg_addr), 64'(cfg_addr_ign));

  assign data_side_ok = !cfg_data_on
                      || masked_eq(64'(bus_data), 64'(cfg_data), 64'(cfg_data_ign));
  assign vec_ok       = cfg_vec_any || (bus_data[7:0] == cfg_vector);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= 1'b0;
      pend_inta <= 1'b0;
    end else if (cyc_start) begin
      pend_addr <= addr_side_ok;
      pend_inta <= (bus_ctype == CT_INTA);
    end else if (bus_rdy) begin
      pend_addr <= 1'b0;
      pend_inta <= 1'b0;
    end
  end

  assign ev_addr = pend_addr && bus_rdy && data_side_ok;
  assign ev_inta = pend_inta && bus_rdy && vec_ok;
  assign ev_spec = cyc_start && (((bus_ctype == CT_FLUSH) && cfg_spec_sel[0])
                              || ((bus_ctype == CT_WBACK) && cfg_spec_sel[1]));
  assign ev_ill  = cyc_start && bus_ctype[2];

  a_r2_pending_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdy && !cyc_start) |=> (!pend_addr && !pend_inta));

  a_r6_inta_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inta |-> $past(cyc_start || pend_inta));
endmodule

// File: rtl/bkpt_watch.sv
module bkpt_watch #(
  parameter int IDLE_W = 16,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  input  logic [HOLD_W-1:0] cfg_hold_limit,
  output logic              ev_idle,
  output logic              ev_hold
);
  logic [IDLE_W-1:0] idle_cnt;
  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      hold_cnt <= '0;
    end else begin
      if (bus_strobe)            idle_cnt <= '0;
      else if (idle_cnt != '1)   idle_cnt <= idle_cnt + 1'b1;
      if (!bus_strobe)           hold_cnt <= '0;
      else if (hold_cnt != '1)   hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign ev_idle = !bus_strobe && (cfg_idle_limit != '0)
                && (IDLE_W'(idle_cnt + 1'b1) == cfg_idle_limit);
  assign ev_hold = bus_strobe && (cfg_hold_limit != '0)
                && (hold_cnt == cfg_hold_limit);

  a_r8_idle_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> (idle_cnt == '0));

  a_r9_hold_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> (hold_cnt == '0));
endmodule

// File: rtl/bkpt_matcher.sv
module bkpt_matcher
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDLE_W = 16,
  parameter int HOLD_W = 4,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic              bus_rdy,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_mio,
  input  logic              bus_wr,
  input  logic              bus_code,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [2:0]        bus_ctype,
  input  logic [NCOND-1:0]  cfg_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_addr_ign,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [DATA_W-1:0] cfg_data_ign,
  input  logic              cfg_data_on,
  input  logic [1:0]        cfg_dir,
  input  logic [1:0]        cfg_space,
  input  logic [1:0]        cfg_fetch,
  input  logic [1:0]        cfg_size,
  input  logic [7:0]        cfg_vector,
  input  logic              cfg_vec_any,
  input  logic [1:0]        cfg_spec_sel,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  input  logic [HOLD_W-1:0] cfg_hold_limit,
  input  logic [1:0]        sync_in,
  input  logic [NCOND-1:0]  stat_clr,
  output logic              halt,
  output logic [NCOND-1:0]  status,
  output logic [1:0]        sync_out
);
  logic             strobe_q;
  logic             cyc_start;
  logic [NCOND-1:0] ev_raw;
  logic [NCOND-1:0] ev_en;
  logic             any_fire;
  logic             local_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= bus_strobe;
  end
  assign cyc_start = bus_strobe && !strobe_q;

  bkpt_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .bus_rdy(bus_rdy),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_mio(bus_mio), .bus_wr(bus_wr),
    .bus_code(bus_code), .bus_be(bus_be), .bus_ctype(bus_ctype),
    .cfg_addr(cfg_addr), .cfg_addr_ign(cfg_addr_ign), .cfg_data(cfg_data),
    .cfg_data_ign(cfg_data_ign), .cfg_data_on(cfg_data_on), .cfg_dir(cfg_dir),
    .cfg_space(cfg_space), .cfg_fetch(cfg_fetch), .cfg_size(cfg_size),
    .cfg_vector(cfg_vector), .cfg_vec_any(cfg_vec_any), .cfg_spec_sel(cfg_spec_sel),
    .ev_addr(ev_raw[C_ADDR]), .ev_spec(ev_raw[C_SPEC]),
    .ev_inta(ev_raw[C_INTA]), .ev_ill(ev_raw[C_ILL])
  );

  bkpt_watch #(.IDLE_W(IDLE_W), .HOLD_W(HOLD_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe),
    .cfg_idle_limit(cfg_idle_limit), .cfg_hold_limit(cfg_hold_limit),
    .ev_idle(ev_raw[C_IDLE]), .ev_hold(ev_raw[C_HOLD])
  );

  assign ev_raw[C_SYNC0] = sync_in[0];
  assign ev_raw[C_SYNC1] = sync_in[1];

  assign ev_en      = ev_raw & cfg_en;
  assign any_fire   = |ev_en;
  assign local_fire = |ev_en[NLOCAL-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      sync_out <= '0;
    end else begin
      status   <= (status & ~stat_clr) | ev_en;
      sync_out <= {local_fire && !halt, any_fire && !halt};
    end
  end

  assign halt = |status;

  for (genvar i = 0; i < NCOND; i++) begin : g_stat
    a_r13_fire_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ev_en[i] |=> status[i]);
  end

  a_r13_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && stat_clr == '0) |=> halt);

  a_r11_sync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out[0] |-> (halt && !$past(halt)));

  a_r11_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out[0] |=> !sync_out[0]);

  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en == '0 && !halt) |=> !halt);
endmodule

// File: tb/bkpt_matcher_test.sv
module bkpt_matcher_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 6;
  localparam int HW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_strobe = 1'b0, bus_rdy = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic bus_mio = 1'b1, bus_wr = 1'b0, bus_code = 1'b0;
  logic [3:0] bus_be = 4'hF;
  logic [2:0] bus_ctype = 3'd0;
  logic [7:0] cfg_en = '0;
  logic [AW-1:0] cfg_addr = '0, cfg_addr_ign = '0;
  logic [DW-1:0] cfg_data = '0, cfg_data_ign = '0;
  logic cfg_data_on = 1'b0;
  logic [1:0] cfg_dir = 2'b11, cfg_space = 2'b11, cfg_fetch = 2'd0, cfg_size = 2'd0;
  logic [7:0] cfg_vector = '0;
  logic cfg_vec_any = 1'b0;
  logic [1:0] cfg_spec_sel = '0;
  logic [IW-1:0] cfg_idle_limit = '0;
  logic [HW-1:0] cfg_hold_limit = '0;
  logic [1:0] sync_in = '0;
  logic [7:0] stat_clr = '0;
  logic halt;
  logic [7:0] status;
  logic [1:0] sync_out;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];
  event chk_ev;

  always #2 clk = ~clk;

  bkpt_matcher #(.ADDR_W(AW), .DATA_W(DW), .IDLE_W(IW), .HOLD_W(HW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_rdy(bus_rdy),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_mio(bus_mio), .bus_wr(bus_wr),
    .bus_code(bus_code), .bus_be(bus_be), .bus_ctype(bus_ctype), .cfg_en(cfg_en),
    .cfg_addr(cfg_addr), .cfg_addr_ign(cfg_addr_ign), .cfg_data(cfg_data),
    .cfg_data_ign(cfg_data_ign), .cfg_data_on(cfg_data_on), .cfg_dir(cfg_dir),
    .cfg_space(cfg_space), .cfg_fetch(cfg_fetch), .cfg_size(cfg_size),
    .cfg_vector(cfg_vector), .cfg_vec_any(cfg_vec_any), .cfg_spec_sel(cfg_spec_sel),
    .cfg_idle_limit(cfg_idle_limit), .cfg_hold_limit(cfg_hold_limit),
    .sync_in(sync_in), .stat_clr(stat_clr), .halt(halt), .status(status),
    .sync_out(sync_out)
  );

  // monitor: pops each expected item and compares it with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({halt, sync_out, status} !== e) begin
          errors++;
          $display("FAIL %s: got halt=%b sync=%b status=%h, expected halt=%b sync=%b status=%h",
                   t, halt, sync_out, status, e[10], e[9:8], e[7:0]);
        end
      end
    end
  end

  // driver side: expected value from the requirements, halt is OR of status
  task automatic expect_out(input string tag, input logic [7:0] st, input logic [1:0] sy);
    exp_q.push_back({(|st), sy, st});
    tag_q.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic bus_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic mio,
                           input logic wr, input logic code, input logic [3:0] be,
                           input logic [2:0] ct, input logic [7:0] clr);
    @(negedge clk);
    bus_strobe = 1'b1; bus_addr = a; bus_data = ~d; bus_mio = mio;
    bus_wr = wr; bus_code = code; bus_be = be; bus_ctype = ct;
    @(negedge clk);
    bus_strobe = 1'b0; bus_rdy = 1'b1; bus_data = d; stat_clr = clr;
    @(negedge clk);
    bus_rdy = 1'b0; stat_clr = '0;
  endtask

  task automatic clear_bits(input logic [7:0] m);
    @(negedge clk); stat_clr = m;
    @(negedge clk); stat_clr = '0;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R13 reset state", 8'h00, 2'b00);

    // R1 direction
    cfg_en = 8'h01; cfg_addr = 16'h1234; cfg_dir = 2'b10;
    bus_cycle(16'h1234, 32'h0, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R1 read blocked by write-only", 8'h00, 2'b00);
    bus_cycle(16'h1234, 32'h0, 1, 1, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R1 write matches", 8'h01, 2'b11);
    clear_bits(8'hFF);
    expect_out("R13 clear returns to idle", 8'h00, 2'b00);

    // R2 masks
    cfg_dir = 2'b11; cfg_addr = 16'h1000; cfg_addr_ign = 16'h0FFF;
    bus_cycle(16'h1ABC, 32'h0, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R2 ignored low address bits", 8'h01, 2'b11);
    clear_bits(8'hFF);
    bus_cycle(16'h2ABC, 32'h0, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R2 cared address bit differs", 8'h00, 2'b00);
    cfg_data_on = 1'b1; cfg_data = 32'h00AB_CD00; cfg_data_ign = 32'hFF00_00FF;
    bus_cycle(16'h1000, 32'h77AB_CD11, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R2 data with outer bytes ignored", 8'h01, 2'b11);
    clear_bits(8'hFF);
    bus_cycle(16'h1000, 32'h77AB_CE11, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R2 data inner byte differs", 8'h00, 2'b00);

    // R3 fetch class with data pattern
    cfg_data = 32'hDEAD_BEEF; cfg_data_ign = '0; cfg_fetch = 2'd2;
    bus_cycle(16'h1000, 32'hDEAD_BEEF, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R3 code-only rejects data access", 8'h00, 2'b00);
    bus_cycle(16'h1000, 32'hDEAD_BEEF, 1, 0, 1, 4'hF, 3'd0, 8'h00);
    expect_out("R3 code fetch with pattern", 8'h01, 2'b11);
    clear_bits(8'hFF);
    cfg_fetch = 2'd1;
    bus_cycle(16'h1000, 32'hDEAD_BEEF, 1, 0, 1, 4'hF, 3'd0, 8'h00);
    expect_out("R3 data-only rejects fetch", 8'h00, 2'b00);
    bus_cycle(16'h1000, 32'hDEAD_BEEF, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R3 data-only accepts data access", 8'h01, 2'b11);
    clear_bits(8'hFF);
    cfg_fetch = 2'd0; cfg_data_on = 1'b0;

    // R4 space
    cfg_space = 2'b01;
    bus_cycle(16'h1000, 32'h0, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R4 memory rejected when I/O only", 8'h00, 2'b00);
    bus_cycle(16'h1000, 32'h0, 0, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R4 I/O accepted", 8'h01, 2'b11);
    clear_bits(8'hFF);
    cfg_space = 2'b11;

    // R5 size
    cfg_size = 2'd2;
    bus_cycle(16'h1000, 32'h0, 1, 0, 0, 4'b0001, 3'd0, 8'h00);
    expect_out("R5 byte rejected for word", 8'h00, 2'b00);
    bus_cycle(16'h1000, 32'h0, 1, 0, 0, 4'b1100, 3'd0, 8'h00);
    expect_out("R5 word accepted", 8'h01, 2'b11);
    clear_bits(8'hFF);
    cfg_size = 2'd3;
    bus_cycle(16'h1000, 32'h0, 1, 0, 0, 4'b0111, 3'd0, 8'h00);
    expect_out("R5 three lanes rejected for dword", 8'h00, 2'b00);
    bus_cycle(16'h1000, 32'h0, 1, 0, 0, 4'b1111, 3'd0, 8'h00);
    expect_out("R5 dword accepted", 8'h01, 2'b11);
    clear_bits(8'hFF);
    cfg_size = 2'd0;

    // R6 interrupt acknowledge
    cfg_en = 8'h04; cfg_vector = 8'h21;
    bus_cycle(16'h1000, 32'h0000_0020, 1, 0, 0, 4'hF, 3'd1, 8'h00);
    expect_out("R6 other vector ignored", 8'h00, 2'b00);
    bus_cycle(16'h0000, 32'h0000_0021, 1, 0, 0, 4'hF, 3'd1, 8'h00);
    expect_out("R6 vector matches", 8'h04, 2'b11);
    clear_bits(8'hFF);
    cfg_vec_any = 1'b1;
    bus_cycle(16'h0000, 32'h0000_0099, 1, 0, 0, 4'hF, 3'd1, 8'h00);
    expect_out("R6 any vector", 8'h04, 2'b11);
    clear_bits(8'hFF);

    // R7 flush / writeback
    cfg_en = 8'h02; cfg_spec_sel = 2'b01;
    bus_cycle(16'h0000, 32'h0, 1, 0, 0, 4'hF, 3'd3, 8'h00);
    expect_out("R7 writeback not selected", 8'h00, 2'b00);
    bus_cycle(16'h0000, 32'h0, 1, 0, 0, 4'hF, 3'd2, 8'h00);
    expect_out("R7 flush selected, sticky after pulse", 8'h02, 2'b00);
    clear_bits(8'hFF);

    // R10 undefined cycle types
    cfg_en = 8'h20; cfg_spec_sel = 2'b00;
    bus_cycle(16'h0000, 32'h0, 1, 0, 0, 4'hF, 3'd3, 8'h00);
    expect_out("R10 defined type ignored", 8'h00, 2'b00);
    bus_cycle(16'h0000, 32'h0, 1, 0, 0, 4'hF, 3'd6, 8'h00);
    expect_out("R10 undefined type breaks", 8'h20, 2'b00);
    clear_bits(8'hFF);

    // R8 idle bus
    @(negedge clk);
    bus_strobe = 1'b1; bus_ctype = 3'd0; bus_addr = 16'h0;
    cfg_en = 8'h08; cfg_idle_limit = 6'd5;
    @(negedge clk);
    bus_strobe = 1'b0;
    repeat (4) @(negedge clk);
    expect_out("R8 idle below limit", 8'h00, 2'b00);
    @(negedge clk);
    expect_out("R8 idle limit reached", 8'h08, 2'b11);
    clear_bits(8'hFF);
    repeat (70) @(negedge clk);
    expect_out("R8 once per idle stretch", 8'h00, 2'b00);
    cfg_en = 8'h00; cfg_idle_limit = '0;

    // R9 strobe held too long
    cfg_en = 8'h10; cfg_hold_limit = 3'd3;
    @(negedge clk);
    bus_strobe = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R9 strobe within limit", 8'h00, 2'b00);
    @(negedge clk);
    expect_out("R9 strobe past limit", 8'h10, 2'b11);
    bus_strobe = 1'b0;
    clear_bits(8'hFF);
    cfg_hold_limit = '0;

    // R11 sync inputs
    cfg_en = 8'hC0;
    @(negedge clk); sync_in = 2'b10;
    @(negedge clk); sync_in = 2'b00;
    expect_out("R11 sync input breaks, only sync_out[0]", 8'h80, 2'b01);
    clear_bits(8'hFF);

    // R12 all enables clear
    cfg_en = 8'h00; cfg_addr = 16'h1234; cfg_addr_ign = '0; cfg_idle_limit = 6'd1;
    bus_cycle(16'h1234, 32'h0, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    bus_cycle(16'h1234, 32'h0, 1, 0, 0, 4'hF, 3'd7, 8'h00);
    @(negedge clk); sync_in = 2'b11;
    @(negedge clk); sync_in = 2'b00;
    expect_out("R12 nothing fires while disabled", 8'h00, 2'b00);
    cfg_idle_limit = '0;

    // R13 selective clear and set-wins
    cfg_en = 8'h21;
    bus_cycle(16'h1234, 32'h0, 1, 0, 0, 4'hF, 3'd0, 8'h00);
    expect_out("R13 first break", 8'h01, 2'b11);
    bus_cycle(16'h0000, 32'h0, 1, 0, 0, 4'hF, 3'd5, 8'h00);
    expect_out("R13 second break accumulates, no new pulse", 8'h21, 2'b00);
    clear_bits(8'h20);
    expect_out("R13 only named bit cleared", 8'h01, 2'b00);
    bus_cycle(16'h1234, 32'h0, 1, 0, 0, 4'hF, 3'd0, 8'h01);
    expect_out("R13 set wins over clear", 8'h01, 2'b00);
    clear_bits(8'h01);
    expect_out("R13 halt drops after clear", 8'h00, 2'b00);

    @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule